// File: doc/BRIEF.md
# Command-Driven SPI Byte Shifter

This block is the data engine of a SPI master. Software or a sequencer hands it one command at a time: an opcode byte, a byte count and, for transfers that send data, a stream of transmit bytes. The opcode bits choose, each on its own, whether bytes are shifted out on MOSI, whether bytes are captured from MISO, which bit of each byte goes first, which SCLK edge changes MOSI and which SCLK edge samples MISO. Captured bytes leave on a second valid/ready stream. When the last bit of the final byte is complete, the block raises a one-cycle done pulse.

The SCLK level at rest comes from a static configuration input. The SCLK rate comes from a divider input: each SCLK half-period lasts the divider value plus one system clocks. When the engine needs a transmit byte that is not yet offered, or holds a received byte that has not been taken, it waits with SCLK at its rest level. Chip select is left to the surrounding logic.

The four classic SPI modes come from combining the rest level with the opcode edge bits. With rest level low, mode 0 samples on rising edges and changes MOSI on falling edges, and mode 1 does the reverse. With rest level high, mode 2 samples on falling edges and changes MOSI on rising edges, and mode 3 does the reverse.

Top module: `spi_cmd_shifter`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1, and `cmd_ready` is 1 only while no command is active. Opcode bits decode as: bit 4 = send on MOSI, bit 5 = capture from MISO, bit 3 = least significant bit first (0 = most significant first), bit 0 = MOSI changes on falling SCLK edges (0 = rising), bit 2 = MISO is sampled on falling SCLK edges (0 = rising).
- R2: `cmd_len` holds the byte count minus one (0 = one byte). Each byte takes exactly 16 SCLK edges. After the final byte, `done` is 1 for exactly one clock.
- R3: Outside a command, and at reset, SCLK equals `cfg_idle_hi`. SCLK is back at that level after every byte.
- R4: Within a byte, consecutive SCLK edges are `cfg_div`+1 system clocks apart.
- R5: MOSI changes only on SCLK edges of the polarity chosen by opcode bit 0. The one exception is the first bit of a byte: when that polarity is the second edge of each bit, the first bit is placed on MOSI before the first edge, while SCLK is still at rest.
- R6: MISO is sampled on SCLK edges of the polarity chosen by opcode bit 2, once per bit.
- R7: Opcode bit 3 sets the bit order for both the sent and the captured byte.
- R8: With opcode bit 4 clear, `tx_ready` stays 0 and MOSI holds its previous value. MOSI is 0 after reset.
- R9: With opcode bit 5 clear, `rx_valid` stays 0 for the whole command.
- R10: While a needed transmit byte is missing, or a captured byte is waiting with `rx_ready` low, SCLK rests at `cfg_idle_hi` and `rx_valid`/`rx_data` hold steady.
- R11: Write opcodes 0x10, 0x11, 0x18, 0x19 and read opcodes 0x20, 0x25, 0x28, 0x2D move correct data with both rest levels. The full-duplex opcodes 0x31 and 0x3C do the same in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idle_hi | input | 1 | SCLK rest level, static while a command runs |
| cfg_div | input | DIV_W | Half-period length minus one, in system clocks |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle; command accepted when both are high |
| cmd_op | input | 8 | Opcode byte |
| cmd_len | input | LEN_W | Byte count minus one |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine wants the next transmit byte |
| tx_data | input | BYTE_W | Transmit byte |
| rx_valid | output | 1 | Captured byte available |
| rx_ready | input | 1 | Consumer takes captured byte |
| rx_data | output | BYTE_W | Captured byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| done | output | 1 | One-clock pulse after the final byte |

## Verification
A transmit byte handshake starts a half-period timer. The first SCLK edge arrives `cfg_div`+1 clocks after that edge. The next 15 edges follow at the same spacing, and `rx_valid` rises one half-period after the 16th edge. `done` comes one clock after the final byte finishes. For a capturing command, the final byte finishes when the last received byte is taken. The bench drives on falling clock edges and reads all outputs one time unit later. It judges each SCLK edge by the spacing between edges and by which edge MOSI moved on. A slave model advances MISO just after each sampling edge and takes MOSI on the opposite edge, so a wrong edge choice shows up as wrong data in the comparison at the end of the command.

// File: rtl/spi_shift_pkg.sv
// Package: shared types and opcode bit positions for the SPI byte shifter.
// Assumes an 8-bit opcode byte; the bit positions below are decoded by the engine.
package spi_shift_pkg;

    localparam int OPB_OUT_FALL = 0;
    localparam int OPB_IN_FALL  = 2;
    localparam int OPB_LSB      = 3;
    localparam int OPB_WR       = 4;
    localparam int OPB_RD       = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_RXW  = 2'd3
    } eng_state_t;

    typedef struct packed {
        logic wr;
        logic rd;
        logic lsb;
        logic out_fall;
        logic in_fall;
    } op_fields_t;

    // Split an opcode byte into its independent control fields.
    function automatic op_fields_t decode_op(input logic [7:0] op);
        op_fields_t f;
        f.wr       = op[OPB_WR];
        f.rd       = op[OPB_RD];
        f.lsb      = op[OPB_LSB];
        f.out_fall = op[OPB_OUT_FALL];
        f.in_fall  = op[OPB_IN_FALL];
        return f;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
// Half-period timer: produces a one-clock tick every (div+1) clocks while run is high.
// Assumes div is stable while run is high; restart reloads the count.
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Count down from div to zero and reload on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= div;
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q <= div;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/spi_edge_decode.sv
// Edge decode: given the current SCLK level, says whether the next toggle drives MOSI,
// samples MISO, and whether a byte's first bit must be presented before the first edge.
// Purely combinational; assumes the fields are held for the whole command.
module spi_edge_decode
    import spi_shift_pkg::*;
(
    input  op_fields_t flds,
    input  logic       sclk_now,
    input  logic       idle_hi,
    output logic       do_out,
    output logic       do_samp,
    output logic       preload
);

    logic next_rises;

    // Classify the upcoming edge and match it against the opcode's edge choices.
    always_comb begin
        next_rises = !sclk_now;
        do_out     = flds.wr && (next_rises ? !flds.out_fall : flds.out_fall);
        do_samp    = flds.rd && (next_rises ? !flds.in_fall  : flds.in_fall);
        // The first edge of each bit leaves the rest level; when MOSI moves on the
        // other edge, bit 0 has to be on the line before the first edge.
        preload    = flds.wr && (flds.out_fall != idle_hi);
    end

endmodule

// File: rtl/spi_tx_shreg.sv
// Transmit shifter: holds one byte and registers MOSI, one bit per drive request.
// Assumes load and drive are never high together; at most W bits leave per byte.
module spi_tx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         first_out,
    input  logic [W-1:0] load_data,
    input  logic         lsb,
    input  logic         drive,
    output logic         mosi
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mosi_q;

    // Load a byte (optionally launching its first bit) or launch the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            if (first_out) begin
                mosi_q <= lsb ? load_data[0] : load_data[W-1];
                sh_q   <= lsb ? (load_data >> 1) : (load_data << 1);
                cnt_q  <= CNT_W'(1);
            end else begin
                sh_q   <= load_data;
                cnt_q  <= '0;
            end
        end else if (drive && (cnt_q < CNT_W'(W))) begin
            mosi_q <= lsb ? sh_q[0] : sh_q[W-1];
            sh_q   <= lsb ? (sh_q >> 1) : (sh_q << 1);
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign mosi = mosi_q;

endmodule

// File: rtl/spi_rx_shreg.sv
// Receive shifter: collects MISO bits into a byte in the selected order.
// Assumes exactly W sample requests between clears.
module spi_rx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         samp,
    input  logic         lsb,
    input  logic         miso,
    output logic [W-1:0] data
);

    logic [W-1:0] data_q;

    // Shift a sampled bit in from the end that matches the bit order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (clear) begin
            data_q <= '0;
        end else if (samp) begin
            data_q <= lsb ? {miso, data_q[W-1:1]} : {data_q[W-2:0], miso};
        end
    end

    assign data = data_q;

endmodule

// File: rtl/spi_cmd_shifter.sv
// SPI master data engine: runs one opcode-steered transfer of (cmd_len+1) bytes.
// Assumes cfg_idle_hi and cfg_div stay constant while a command is active and that
// chip select is handled outside. Each byte: load, rest half-period, 16 edges, rest half-period.
module spi_cmd_shifter
    import spi_shift_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_idle_hi,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_op,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              done
);

    localparam int EDGES = 2 * BYTE_W;
    localparam int EC_W  = $clog2(EDGES + 1);

    eng_state_t        state_q;
    op_fields_t        flds_q;
    logic [LEN_W-1:0]  left_q;
    logic              sclk_q;
    logic [EC_W-1:0]   ecnt_q;
    logic              rx_valid_q;
    logic [BYTE_W-1:0] rx_data_q;
    logic              done_q;

    logic              tick;
    logic              do_out;
    logic              do_samp;
    logic              preload;
    logic              take_byte;
    logic              edge_now;
    logic              byte_end;
    logic              byte_fin;
    logic [BYTE_W-1:0] rx_word;

    // Handshake and sequencing strobes derived from the state.
    always_comb begin
        take_byte = (state_q == ST_LOAD) && (!flds_q.wr || tx_valid);
        edge_now  = tick && (ecnt_q != EC_W'(EDGES));
        byte_end  = tick && (ecnt_q == EC_W'(EDGES));
        byte_fin  = (byte_end && !flds_q.rd) || ((state_q == ST_RXW) && rx_ready);
    end

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (take_byte),
        .run     (state_q == ST_RUN),
        .div     (cfg_div),
        .tick    (tick)
    );

    spi_edge_decode u_edge (
        .flds     (flds_q),
        .sclk_now (sclk_q),
        .idle_hi  (cfg_idle_hi),
        .do_out   (do_out),
        .do_samp  (do_samp),
        .preload  (preload)
    );

    spi_tx_shreg #(.W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_byte && flds_q.wr),
        .first_out (preload),
        .load_data (tx_data),
        .lsb       (flds_q.lsb),
        .drive     (edge_now && do_out),
        .mosi      (mosi)
    );

    spi_rx_shreg #(.W(BYTE_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take_byte),
        .samp  (edge_now && do_samp),
        .lsb   (flds_q.lsb),
        .miso  (miso),
        .data  (rx_word)
    );

    // Command sequencer: accept, load bytes, toggle SCLK, hand off captures, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            flds_q     <= '0;
            left_q     <= '0;
            sclk_q     <= cfg_idle_hi;
            ecnt_q     <= '0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= cfg_idle_hi;
                    if (cmd_valid) begin
                        flds_q  <= decode_op(cmd_op);
                        left_q  <= cmd_len;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (take_byte) begin
                        ecnt_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (edge_now) begin
                        sclk_q <= ~sclk_q;
                        ecnt_q <= ecnt_q + 1'b1;
                    end else if (byte_end && flds_q.rd) begin
                        rx_valid_q <= 1'b1;
                        rx_data_q  <= rx_word;
                        state_q    <= ST_RXW;
                    end
                end
                ST_RXW: begin
                    if (rx_ready) begin
                        rx_valid_q <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (byte_fin) begin
                if (left_q == '0) begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end else begin
                    left_q  <= left_q - 1'b1;
                    state_q <= ST_LOAD;
                end
            end
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign tx_ready  = (state_q == ST_LOAD) && flds_q.wr;
    assign rx_valid  = rx_valid_q;
    assign rx_data   = rx_data_q;
    assign sclk      = sclk_q;
    assign done      = done_q;

endmodule

// File: rtl/spi_cmd_shifter_chk.sv
// Checker for the SPI byte shifter: temporal properties on ports and sequencer state.
// Attached to every instance of the top module by the bind below.
module spi_cmd_shifter_chk
    import spi_shift_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_idle_hi,
    input logic              cmd_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [BYTE_W-1:0] rx_data,
    input logic              sclk,
    input logic              mosi,
    input logic              done,
    input eng_state_t        state_q,
    input op_fields_t        flds_q
);

    // R2: the completion strobe lasts one clock.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: resting engine keeps SCLK at the configured level.
    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && $past(cmd_ready) && $stable(cfg_idle_hi)) |-> (sclk == cfg_idle_hi));

    // R8: no transmit request and no MOSI movement when sending is off.
    assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !flds_q.wr) |=> ($stable(mosi) && !tx_ready));

    // R9: no captured byte is offered when capturing is off.
    assert_no_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> flds_q.rd);

    // R10: a waiting capture is held unchanged until taken.
    assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R10: a transmit stall keeps SCLK at rest.
    assert_tx_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |-> (sclk == cfg_idle_hi));

    // R3: SCLK never moves while loading or waiting on a capture handoff.
    assert_sclk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOAD) || (state_q == ST_RXW)) |=> $stable(sclk));

endmodule

bind spi_cmd_shifter spi_cmd_shifter_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_idle_hi (cfg_idle_hi),
    .cmd_ready   (cmd_ready),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .sclk        (sclk),
    .mosi        (mosi),
    .done        (done),
    .state_q     (state_q),
    .flds_q      (flds_q)
);

// File: tb/spi_cmd_shifter_tb.sv
// Bench: directed opcode sweep over both rest levels plus seeded random commands,
// with a SPI slave model that serves MISO and captures MOSI.
module spi_cmd_shifter_tb;

    localparam int MAXB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_idle_hi = 1'b1;
    logic [7:0] cfg_div = 8'd1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [7:0] cmd_op = 8'h00;
    logic [15:0] cmd_len = 16'd0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = 8'h00;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic [7:0] rx_data;
    logic       sclk;
    logic       mosi;
    logic       miso = 1'b0;
    logic       done;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spi_cmd_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_idle_hi(cfg_idle_hi), .cfg_div(cfg_div),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_len(cmd_len),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .done(done)
    );

    // Per-command context shared with the slave model and monitors.
    logic [7:0] tx_b [MAXB];
    logic [7:0] sl_b [MAXB];
    logic [7:0] s_cap [MAXB];
    logic [7:0] s_acc;
    logic cur_wr, cur_rd, cur_lsb, cur_ofall, cur_ifall;
    logic s_active = 1'b0;
    int   s_rbit, s_rbyte, s_tbit, s_tbyte;
    int   cyc, last_tog, tog, hp_bad, edge_bad, mosi_chg, stall_bad;
    logic txr_seen, prev_sclk, prev_mosi;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic slave_bit(input int by, input int bi);
        if (by >= MAXB) return 1'b0;
        return cur_lsb ? sl_b[by][bi] : sl_b[by][7 - bi];
    endfunction

    // Slave model: captures MOSI opposite the drive edge, advances MISO after each sample edge.
    always @(sclk) begin
        if (s_active) begin
            if (cur_wr && ((sclk === 1'b1) == cur_ofall)) begin
                s_acc = cur_lsb ? {mosi, s_acc[7:1]} : {s_acc[6:0], mosi};
                s_rbit++;
                if (s_rbit == 8) begin
                    if (s_rbyte < MAXB) s_cap[s_rbyte] = s_acc;
                    s_rbyte++;
                    s_rbit = 0;
                end
            end
            if (cur_rd && ((sclk === 1'b1) != cur_ifall)) begin
                #1;
                s_tbit++;
                if (s_tbit == 8) begin
                    s_tbit = 0;
                    s_tbyte++;
                end
                miso = slave_bit(s_tbyte, s_tbit);
            end
        end
    end

    // Line monitor: edge spacing (R4), MOSI edge choice (R5), MOSI hold and tx_ready (R8).
    always @(negedge clk) begin
        if (s_active) begin
            #1;
            cyc++;
            if (tx_ready) txr_seen = 1'b1;
            if (sclk != prev_sclk) begin
                tog++;
                if ((tog % 16) != 1 && (cyc - last_tog) != int'(cfg_div) + 1) hp_bad++;
                last_tog = cyc;
            end
            if (mosi != prev_mosi) begin
                mosi_chg++;
                if (sclk != prev_sclk) begin
                    if (sclk != !cur_ofall) edge_bad++;
                end else if (sclk != cfg_idle_hi) begin
                    edge_bad++;
                end
            end
            prev_sclk = sclk;
            prev_mosi = mosi;
        end
    end

    task automatic do_cmd(input logic [7:0] op, input int nb, input int dv,
                          input logic idle, input int bp);
        int got;
        bit seen_done;
        int done_cnt;
        int rx_bad;
        int cap_bad;
        logic [7:0] rx_got [MAXB];
        logic mosi_before;
        cfg_idle_hi = idle;
        cfg_div = 8'(dv);
        repeat (3) @(negedge clk);
        #1;
        chk(sclk == idle, "R3 rest level before command", int'(sclk), int'(idle));
        for (int i = 0; i < nb; i++) begin
            tx_b[i] = 8'($urandom);
            sl_b[i] = 8'($urandom);
        end
        cur_wr = op[4]; cur_rd = op[5]; cur_lsb = op[3];
        cur_ofall = op[0]; cur_ifall = op[2];
        s_rbit = 0; s_rbyte = 0; s_tbit = 0; s_tbyte = 0; s_acc = 8'h00;
        miso = cur_rd ? slave_bit(0, 0) : 1'b0;
        cyc = 0; last_tog = 0; tog = 0; hp_bad = 0; edge_bad = 0;
        mosi_chg = 0; stall_bad = 0; txr_seen = 1'b0;
        prev_sclk = sclk; prev_mosi = mosi; mosi_before = mosi;
        got = 0; seen_done = 0; done_cnt = 0;
        s_active = 1'b1;
        fork
            begin
                @(negedge clk);
                cmd_valid = 1'b1; cmd_op = op; cmd_len = 16'(nb - 1);
                #1;
                while (!cmd_ready) begin @(negedge clk); #1; end
                @(negedge clk);
                cmd_valid = 1'b0;
                if (cur_wr) begin
                    for (int k = 0; k < nb; k++) begin
                        repeat ($urandom % (bp + 1)) @(negedge clk);
                        tx_valid = 1'b1; tx_data = tx_b[k];
                        #1;
                        while (!tx_ready) begin @(negedge clk); #1; end
                        @(negedge clk);
                        tx_valid = 1'b0;
                    end
                end
            end
            begin
                while (!seen_done) begin
                    @(negedge clk);
                    rx_ready = (($urandom % 4) >= bp);
                    #1;
                    if (done) begin done_cnt++; seen_done = 1; end
                    if ((tx_ready && !tx_valid) || (rx_valid && !rx_ready))
                        if (sclk != idle) stall_bad++;
                    if (rx_valid && rx_ready && got < MAXB) begin
                        rx_got[got] = rx_data;
                        got++;
                    end
                end
                rx_ready = 1'b0;
                @(negedge clk);
                #1;
                if (done) done_cnt++;
            end
        join
        s_active = 1'b0;
        chk(done_cnt == 1, "R2 single done pulse", done_cnt, 1);
        chk(sclk == idle, "R3 rest level after command", int'(sclk), int'(idle));
        chk(hp_bad == 0, "R4 edge spacing", hp_bad, 0);
        chk(stall_bad == 0, "R10 stall at rest level", stall_bad, 0);
        if (cur_wr) begin
            cap_bad = 0;
            for (int i = 0; i < nb; i++) if (s_cap[i] != tx_b[i]) cap_bad++;
            chk(s_rbyte == nb && s_rbit == 0, "R2 bytes seen by slave", s_rbyte, nb);
            chk(cap_bad == 0, "R5 R7 R11 MOSI data", int'(s_cap[0]), int'(tx_b[0]));
            chk(edge_bad == 0, "R5 MOSI edge", edge_bad, 0);
        end else begin
            chk(mosi == mosi_before && mosi_chg == 0, "R8 MOSI held", mosi_chg, 0);
            chk(!txr_seen, "R8 tx_ready low", int'(txr_seen), 0);
        end
        if (cur_rd) begin
            rx_bad = 0;
            for (int i = 0; i < nb; i++) if (rx_got[i] != sl_b[i]) rx_bad++;
            chk(got == nb, "R2 R1 captured byte count", got, nb);
            chk(rx_bad == 0, "R6 R7 R11 MISO data", int'(rx_got[0]), int'(sl_b[0]));
        end else begin
            chk(got == 0, "R9 no captured bytes", got, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] ops [10] = '{8'h10, 8'h11, 8'h18, 8'h19, 8'h20,
                                 8'h25, 8'h28, 8'h2D, 8'h31, 8'h3C};
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #1;
        chk(sclk == 1'b1, "R3 reset rest level", int'(sclk), 1);
        chk(mosi == 1'b0, "R8 reset MOSI", int'(mosi), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(cmd_ready && !tx_ready && !rx_valid && !done, "R1 idle after reset",
            int'({cmd_ready, tx_ready, rx_valid, done}), 8);
        // Directed sweep: every opcode under both rest levels (all four modes).
        for (int idl = 0; idl < 2; idl++)
            for (int o = 0; o < 10; o++)
                do_cmd(ops[o], 2, 1, idl[0], 1);
        // Corners: fastest clock with one byte, longest burst, heavy backpressure.
        do_cmd(8'h11, 1, 0, 1'b0, 0);
        do_cmd(8'h2D, 1, 0, 1'b1, 0);
        do_cmd(8'h31, MAXB, 0, 1'b0, 0);
        do_cmd(8'h19, 3, 2, 1'b1, 3);
        do_cmd(8'h28, 3, 3, 1'b0, 3);
        // Seeded random commands.
        for (int n = 0; n < 24; n++)
            do_cmd(ops[$urandom % 10], 1 + int'($urandom % 6), int'($urandom % 4),
                   1'($urandom), int'($urandom % 4));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule